// File: doc/BRIEF.md
# Two-Output PWM Action Qualifier with Continuous Force

This block turns time-base events into two PWM levels, A and B. Each cycle it looks at the counter value, the counting direction and the zero and period event strobes. From these it works out four events: counter at zero, counter at period, compare-A match while counting up, and compare-B match while counting up. For each output, a programmable action word turns these events into a new level. Both outputs see all four events. Output A is normally shaped by compare A and output B by compare B, and both share the period of the common time base.

A continuous software force can hold either output low or high, whatever the events do. New force values are written into a shadow register. They reach the active force register at a chosen reload point: counter zero, counter period, either of the two, or at once. All registers are loaded through simple write strobes with data, and a write takes effect from the cycle after the write.

Each output is a two-state machine with the states `LVL_LOW` and `LVL_HIGH`:
- **Set**: `LVL_LOW` moves to `LVL_HIGH` on a forced-high, or on a winning drive-high or toggle action.
- **Clear**: `LVL_HIGH` moves to `LVL_LOW` on a forced-low, or on a winning drive-low or toggle action.
- **Hold**: in every other case the state stays where it is.

The reload point of the force shadow is an enumerated selector with four settings: `RLD_ZERO`, `RLD_PRD`, `RLD_BOTH` and `RLD_NOW`.

Top module: `aq_pwm_top`

## Requirements
- R1: Reset is asynchronous and active low. During and after reset both outputs are low. Reset also clears both compare registers, both action words, the force shadow, the active force and the reload select, all to zero.
- R2: Action word bit positions: bits 1:0 give the action on counter-zero, bits 3:2 on counter-period, bits 5:4 on compare-A-up and bits 9:8 on compare-B-up. Bits 7:6 have no effect. Both outputs respond to all four events through their own word.
- R3: Action codes: 00 means no action, 01 drives low, 10 drives high and 11 toggles. The output is registered: an event presented in a cycle sets the output level seen after that clock edge.
- R4: A compare-A event occurs when ctr_up is 1 and ctr_val equals the compare A register. A compare-B event follows the same rule with the compare B register. While ctr_up is 0, no compare event occurs.
- R5: When several events occur in one cycle, only the one with the highest priority is applied, even if its code is 00. The order from highest to lowest is compare-B, compare-A, period, zero.
- R6: A write to a compare register or an action word is used from the next cycle. An event in the same cycle as the write uses the old value.
- R7: Force data holds output A in bits 1:0 and output B in bits 3:2. Code 01 forces low, 10 forces high, and 00 or 11 forces nothing. While the active force code of an output is 01 or 10, the output takes that level at every edge, overriding all actions. When the force is released, the output keeps its last level.
- R8: Reload select codes: 00 loads the shadow into the active force at a zero event, 01 at a period event, and 10 at either. A force write in the same cycle as a reload is loaded. The output follows the new active force from the next edge.
- R9: With reload select 11, a force write reaches the active force at the edge of the write, and controls the output from the following edge.
- R10: Normal polarity (word 0x10A for B, 0x01A for A) goes high at zero and at period and low on the compare-up match. Inverted polarity (A word 0x025) goes low at zero and at period and high on the compare-A-up match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_val | input | CTR_W | Time-base counter value |
| ctr_up | input | 1 | 1 while the counter counts up |
| evt_zero | input | 1 | Counter-equals-zero strobe |
| evt_period | input | 1 | Counter-equals-period strobe |
| cmpa_wr | input | 1 | Write strobe for compare A |
| cmpa_data | input | CTR_W | New compare A value |
| cmpb_wr | input | 1 | Write strobe for compare B |
| cmpb_data | input | CTR_W | New compare B value |
| acta_wr | input | 1 | Write strobe for the output A action word |
| acta_data | input | 10 | New output A action word |
| actb_wr | input | 1 | Write strobe for the output B action word |
| actb_data | input | 10 | New output B action word |
| frc_wr | input | 1 | Write strobe for the force shadow |
| frc_data | input | 4 | New force codes (A in 1:0, B in 3:2) |
| rld_wr | input | 1 | Write strobe for the reload select |
| rld_data | input | 2 | New reload select |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Two pairs of functions can fall in the same cycle: an event action and an active force, and a compare-up match together with a zero or period strobe. Setting a compare value to the count that is present while zero or period is strobed (or setting both compares equal) provokes the second pair. Each such case is judged against the fixed compare-B, compare-A, period, zero order, choosing action codes so that each possible winner gives a different level. For the force, reload events are strobed while a force is active and while shadow writes are pending. The bench then checks that the output does not follow the action before the active force changes, and does follow the force level after it.

// File: rtl/aq_pkg.sv
package aq_pkg;

    localparam int ACT_W    = 10;
    localparam int FRC_BITS = 2;
    localparam int NUM_OUT  = 2;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_NONE = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_OFF  = 2'b11
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO = 2'b00,
        RLD_PRD  = 2'b01,
        RLD_BOTH = 2'b10,
        RLD_NOW  = 2'b11
    } rld_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic cbu;
        logic cau;
        logic prd;
        logic zro;
    } evt_t;

    // Highest-priority event wins, even when its code is ACT_NONE.
    function automatic act_e pick_action(input logic [ACT_W-1:0] word,
                                         input evt_t ev);
        act_e res;
        if (ev.cbu)      res = act_e'(word[9:8]);
        else if (ev.cau) res = act_e'(word[5:4]);
        else if (ev.prd) res = act_e'(word[3:2]);
        else if (ev.zro) res = act_e'(word[1:0]);
        else             res = ACT_NONE;
        return res;
    endfunction

endpackage

// File: rtl/aq_cmp_unit.sv
module aq_cmp_unit #(
    parameter int CTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTR_W-1:0] ctr_val_i,
    input  logic             ctr_up_i,
    input  logic             wr_i,
    input  logic [CTR_W-1:0] wr_data_i,
    output logic             hit_o
);

    logic [CTR_W-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cmp_q <= '0;
        else if (wr_i) cmp_q <= wr_data_i;
    end

    always_comb begin
        hit_o = ctr_up_i && (ctr_val_i == cmp_q);
    end

endmodule

// File: rtl/aq_force_ctrl.sv
module aq_force_ctrl #(
    parameter  int NUM_OUT = 2,
    localparam int FRC_W   = aq_pkg::FRC_BITS * NUM_OUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_zero_i,
    input  logic             evt_period_i,
    input  logic             frc_wr_i,
    input  logic [FRC_W-1:0] frc_data_i,
    input  logic             rld_wr_i,
    input  logic [1:0]       rld_data_i,
    output logic [FRC_W-1:0] frc_act_o,
    output logic [1:0]       rld_sel_o
);
    import aq_pkg::*;

    rld_e             rld_q;
    logic [FRC_W-1:0] shadow_q, shadow_d;
    logic [FRC_W-1:0] active_q, active_d;
    logic             load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rld_q <= RLD_ZERO;
        else if (rld_wr_i) rld_q <= rld_e'(rld_data_i);
    end

    always_comb begin
        shadow_d = frc_wr_i ? frc_data_i : shadow_q;
        unique case (rld_q)
            RLD_ZERO: load = evt_zero_i;
            RLD_PRD:  load = evt_period_i;
            RLD_BOTH: load = evt_zero_i | evt_period_i;
            RLD_NOW:  load = 1'b1;
            default:  load = 1'b0;
        endcase
        active_d = load ? shadow_d : active_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            shadow_q <= shadow_d;
            active_q <= active_d;
        end
    end

    assign frc_act_o = active_q;
    assign rld_sel_o = rld_q;

endmodule

// File: rtl/aq_channel.sv
module aq_channel #(
    parameter int ACT_W = aq_pkg::ACT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ACT_W-1:0]  wr_data_i,
    input  aq_pkg::evt_t      evt_i,
    input  logic [1:0]        frc_i,
    output logic              pwm_o
);
    import aq_pkg::*;

    logic [ACT_W-1:0] word_q;
    lvl_e             state_q, state_d;
    act_e             act_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (wr_i) word_q <= wr_data_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // next state: force first, then the winning action
    always_comb begin
        act_sel = pick_action(word_q, evt_i);
        state_d = state_q;
        unique case (state_q)
            LVL_LOW: begin
                if (frc_i == FRC_HIGH)
                    state_d = LVL_HIGH;
                else if (frc_i == FRC_LOW)
                    state_d = LVL_LOW;
                else if (act_sel == ACT_HIGH || act_sel == ACT_TOGGLE)
                    state_d = LVL_HIGH;
            end
            LVL_HIGH: begin
                if (frc_i == FRC_LOW)
                    state_d = LVL_LOW;
                else if (frc_i == FRC_HIGH)
                    state_d = LVL_HIGH;
                else if (act_sel == ACT_LOW || act_sel == ACT_TOGGLE)
                    state_d = LVL_LOW;
            end
            default: state_d = LVL_LOW;
        endcase
    end

    // outputs
    always_comb begin
        pwm_o = (state_q == LVL_HIGH);
    end

endmodule

// File: rtl/aq_pwm_top.sv
module aq_pwm_top #(
    parameter int CTR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CTR_W-1:0]         ctr_val,
    input  logic                     ctr_up,
    input  logic                     evt_zero,
    input  logic                     evt_period,
    input  logic                     cmpa_wr,
    input  logic [CTR_W-1:0]         cmpa_data,
    input  logic                     cmpb_wr,
    input  logic [CTR_W-1:0]         cmpb_data,
    input  logic                     acta_wr,
    input  logic [aq_pkg::ACT_W-1:0] acta_data,
    input  logic                     actb_wr,
    input  logic [aq_pkg::ACT_W-1:0] actb_data,
    input  logic                     frc_wr,
    input  logic [3:0]               frc_data,
    input  logic                     rld_wr,
    input  logic [1:0]               rld_data,
    output logic                     pwm_a,
    output logic                     pwm_b
);
    import aq_pkg::*;

    localparam int FRC_W = FRC_BITS * NUM_OUT;

    logic [NUM_OUT-1:0]     cmp_hit;
    logic [NUM_OUT-1:0]     cmp_wr;
    logic [CTR_W-1:0]       cmp_data [NUM_OUT];
    logic [NUM_OUT-1:0]     act_wr;
    logic [ACT_W-1:0]       act_data [NUM_OUT];
    logic [NUM_OUT-1:0]     pwm;
    logic [FRC_W-1:0]       force_act;
    logic [1:0]             rld_sel_q;
    evt_t                   evt;

    always_comb begin
        cmp_wr      = {cmpb_wr, cmpa_wr};
        cmp_data[0] = cmpa_data;
        cmp_data[1] = cmpb_data;
        act_wr      = {actb_wr, acta_wr};
        act_data[0] = acta_data;
        act_data[1] = actb_data;
        evt.zro     = evt_zero;
        evt.prd     = evt_period;
        evt.cau     = cmp_hit[0];
        evt.cbu     = cmp_hit[1];
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        aq_cmp_unit #(.CTR_W(CTR_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctr_val_i (ctr_val),
            .ctr_up_i  (ctr_up),
            .wr_i      (cmp_wr[g]),
            .wr_data_i (cmp_data[g]),
            .hit_o     (cmp_hit[g])
        );

        aq_channel #(.ACT_W(ACT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (act_wr[g]),
            .wr_data_i (act_data[g]),
            .evt_i     (evt),
            .frc_i     (force_act[FRC_BITS*g +: FRC_BITS]),
            .pwm_o     (pwm[g])
        );
    end

    aq_force_ctrl #(.NUM_OUT(NUM_OUT)) u_frc (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_zero_i   (evt_zero),
        .evt_period_i (evt_period),
        .frc_wr_i     (frc_wr),
        .frc_data_i   (frc_data),
        .rld_wr_i     (rld_wr),
        .rld_data_i   (rld_data),
        .frc_act_o    (force_act),
        .rld_sel_o    (rld_sel_q)
    );

    assign pwm_a = pwm[0];
    assign pwm_b = pwm[1];

endmodule

// File: rtl/aq_checker.sv
module aq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_zero,
    input logic       evt_period,
    input logic [1:0] cmp_hit,
    input logic       frc_wr,
    input logic [3:0] frc_data,
    input logic [1:0] rld_sel,
    input logic [3:0] force_act,
    input logic       pwm_a,
    input logic       pwm_b
);

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b && force_act == 4'b0000)); // R1

    AST_FORCE_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        force_act[1:0] == 2'b01 |=> !pwm_a); // R7

    AST_FORCE_HIGH_A: assert property (@(posedge clk) disable iff (!rst_n)
        force_act[1:0] == 2'b10 |=> pwm_a); // R7

    AST_FORCE_LOW_B: assert property (@(posedge clk) disable iff (!rst_n)
        force_act[3:2] == 2'b01 |=> !pwm_b); // R7

    AST_FORCE_HIGH_B: assert property (@(posedge clk) disable iff (!rst_n)
        force_act[3:2] == 2'b10 |=> pwm_b); // R7

    AST_QUIET_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_zero && !evt_period && cmp_hit == 2'b00 &&
         force_act[1:0] != 2'b01 && force_act[1:0] != 2'b10) |=> $stable(pwm_a)); // R3

    AST_QUIET_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_zero && !evt_period && cmp_hit == 2'b00 &&
         force_act[3:2] != 2'b01 && force_act[3:2] != 2'b10) |=> $stable(pwm_b)); // R3

    AST_RELOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_sel == 2'b11 && frc_wr) |=> force_act == $past(frc_data)); // R9

    AST_ZERO_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_sel == 2'b00 && !evt_zero) |=> $stable(force_act)); // R8

    AST_PRD_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_sel == 2'b01 && !evt_period) |=> $stable(force_act)); // R8

endmodule

bind aq_pwm_top aq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .cmp_hit    (cmp_hit),
    .frc_wr     (frc_wr),
    .frc_data   (frc_data),
    .rld_sel    (rld_sel_q),
    .force_act  (force_act),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b)
);

// File: tb/sim_aq_pwm_top.sv
module sim_aq_pwm_top;

    localparam int CTR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CTR_W-1:0] ctr_val = '0;
    logic             ctr_up = 1'b0;
    logic             evt_zero = 1'b0;
    logic             evt_period = 1'b0;
    logic             cmpa_wr = 1'b0;
    logic [CTR_W-1:0] cmpa_data = '0;
    logic             cmpb_wr = 1'b0;
    logic [CTR_W-1:0] cmpb_data = '0;
    logic             acta_wr = 1'b0;
    logic [9:0]       acta_data = '0;
    logic             actb_wr = 1'b0;
    logic [9:0]       actb_data = '0;
    logic             frc_wr = 1'b0;
    logic [3:0]       frc_data = '0;
    logic             rld_wr = 1'b0;
    logic [1:0]       rld_data = '0;
    logic             pwm_a, pwm_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    aq_pwm_top #(.CTR_W(CTR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ctr_val(ctr_val), .ctr_up(ctr_up),
        .evt_zero(evt_zero), .evt_period(evt_period),
        .cmpa_wr(cmpa_wr), .cmpa_data(cmpa_data),
        .cmpb_wr(cmpb_wr), .cmpb_data(cmpb_data),
        .acta_wr(acta_wr), .acta_data(acta_data),
        .actb_wr(actb_wr), .actb_data(actb_data),
        .frc_wr(frc_wr), .frc_data(frc_data),
        .rld_wr(rld_wr), .rld_data(rld_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    typedef struct packed {
        logic [15:0] ctr;
        logic        up;
        logic        z;
        logic        p;
        logic        ea;
        logic        eb;
        logic        dn;
    } vec_t;

    // normal polarity: A word 0x01A with cmp A = 3, B word 0x10A with cmp B = 5
    localparam vec_t VT [11] = '{
        '{16'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{16'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{16'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{16'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'd7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{16'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{16'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{16'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{16'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{16'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'd7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // called at a falling edge: one rising edge passes, strobes clear at the next fall
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        evt_zero = 0; evt_period = 0; ctr_up = 0; ctr_val = '0;
        cmpa_wr = 0; cmpb_wr = 0; acta_wr = 0; actb_wr = 0; frc_wr = 0; rld_wr = 0;
    endtask

    task automatic step(input logic [15:0] c, input logic up, input logic z, input logic p);
        ctr_val = c; ctr_up = up; evt_zero = z; evt_period = p;
        tick();
    endtask

    task automatic idle();
        tick();
    endtask

    task automatic w_cmpa(input logic [15:0] v); cmpa_wr = 1; cmpa_data = v; tick(); endtask
    task automatic w_cmpb(input logic [15:0] v); cmpb_wr = 1; cmpb_data = v; tick(); endtask
    task automatic w_acta(input logic [9:0] v);  acta_wr = 1; acta_data = v; tick(); endtask
    task automatic w_actb(input logic [9:0] v);  actb_wr = 1; actb_data = v; tick(); endtask
    task automatic w_frc(input logic [3:0] v);   frc_wr = 1; frc_data = v; tick(); endtask
    task automatic w_rld(input logic [1:0] v);   rld_wr = 1; rld_data = v; tick(); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", pwm_a, 1'b0, "A in reset");
        chk("R1", pwm_b, 1'b0, "B in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // cleared action words and compares (0): events change nothing
        step(16'd0, 1'b1, 1'b1, 1'b1);
        chk("R1", pwm_a, 1'b0, "A with cleared words");
        chk("R1", pwm_b, 1'b0, "B with cleared words");

        w_cmpa(16'd3);
        w_cmpb(16'd5);
        w_actb(10'h10A);
        // action write and zero event in one cycle: A uses old word
        acta_wr = 1; acta_data = 10'h01A; ctr_val = 16'd9; evt_zero = 1;
        tick();
        chk("R6", pwm_a, 1'b0, "A old word at write cycle");
        chk("R2", pwm_b, 1'b1, "B zero field high");

        // vector table
        for (int i = 0; i < 11; i++) begin
            step(VT[i].ctr, VT[i].up, VT[i].z, VT[i].p);
            if (VT[i].dn) begin
                chk("R4", pwm_a, VT[i].ea, $sformatf("row %0d A down count", i));
                chk("R4", pwm_b, VT[i].eb, $sformatf("row %0d B down count", i));
            end else begin
                chk("R10", pwm_a, VT[i].ea, $sformatf("row %0d A", i));
                chk("R3", pwm_b, VT[i].eb, $sformatf("row %0d B", i));
            end
        end

        // inverted polarity on A
        w_acta(10'h025);
        step(16'd0, 1'b1, 1'b1, 1'b0);
        chk("R10", pwm_a, 1'b0, "inverted zero");
        step(16'd3, 1'b1, 1'b0, 1'b0);
        chk("R10", pwm_a, 1'b1, "inverted cmp A up");
        step(16'd7, 1'b1, 1'b0, 1'b1);
        chk("R10", pwm_a, 1'b0, "inverted period");

        // toggle
        w_acta(10'h030);
        step(16'd3, 1'b1, 1'b0, 1'b0);
        chk("R3", pwm_a, 1'b1, "toggle up");
        step(16'd3, 1'b1, 1'b0, 1'b0);
        chk("R3", pwm_a, 1'b0, "toggle down");

        // bits 7:6 only: no effect
        w_acta(10'h0C0);
        step(16'd3, 1'b1, 1'b1, 1'b1);
        chk("R2", pwm_a, 1'b0, "bits 7:6 ignored");

        // priorities
        w_acta(10'h009);
        step(16'd9, 1'b0, 1'b1, 1'b1);
        chk("R5", pwm_a, 1'b1, "period over zero");
        w_acta(10'h018);
        step(16'd3, 1'b1, 1'b0, 1'b1);
        chk("R5", pwm_a, 1'b0, "cmp A over period");
        w_cmpb(16'd3);
        w_acta(10'h210);
        step(16'd3, 1'b1, 1'b0, 1'b0);
        chk("R5", pwm_a, 1'b1, "cmp B over cmp A");
        chk("R4", pwm_b, 1'b0, "B cmp B up low");
        w_acta(10'h010);
        step(16'd3, 1'b1, 1'b0, 1'b0);
        chk("R5", pwm_a, 1'b1, "cmp B no-action hides cmp A");
        w_cmpb(16'd5);

        // force, reload at zero (reset select)
        w_acta(10'h001);
        w_actb(10'h002);
        step(16'd9, 1'b0, 1'b1, 1'b0);
        chk("R3", pwm_a, 1'b0, "A zero low");
        chk("R3", pwm_b, 1'b1, "B zero high");
        w_frc(4'b0010);
        chk("R8", pwm_a, 1'b0, "shadow only after write");
        step(16'd9, 1'b0, 1'b1, 1'b0);
        chk("R8", pwm_a, 1'b0, "reload edge uses old force");
        idle();
        chk("R8", pwm_a, 1'b1, "forced high after zero reload");
        step(16'd9, 1'b0, 1'b1, 1'b0);
        chk("R7", pwm_a, 1'b1, "force overrides zero low");

        // reload at period
        w_rld(2'b01);
        w_frc(4'b0100);
        step(16'd9, 1'b0, 1'b1, 1'b0);
        chk("R8", pwm_b, 1'b1, "zero does not reload in period mode");
        step(16'd7, 1'b1, 1'b0, 1'b1);
        chk("R8", pwm_b, 1'b1, "period reload edge");
        idle();
        chk("R8", pwm_b, 1'b0, "B forced low after period reload");
        chk("R7", pwm_a, 1'b1, "A keeps level after release");

        // immediate reload
        w_rld(2'b11);
        w_frc(4'b0001);
        chk("R9", pwm_a, 1'b1, "write edge keeps old");
        idle();
        chk("R9", pwm_a, 1'b0, "forced low one edge later");

        // code 11 forces nothing
        w_frc(4'b1111);
        w_acta(10'h002);
        step(16'd9, 1'b0, 1'b1, 1'b0);
        chk("R7", pwm_a, 1'b1, "code 11 A no force");
        chk("R7", pwm_b, 1'b1, "code 11 B no force");

        // reload at either event
        w_rld(2'b10);
        w_frc(4'b0001);
        chk("R8", pwm_a, 1'b1, "either mode shadow only");
        step(16'd7, 1'b1, 1'b0, 1'b1);
        idle();
        chk("R8", pwm_a, 1'b0, "either mode period reload");
        w_frc(4'b0000);
        step(16'd9, 1'b0, 1'b1, 1'b0);
        chk("R8", pwm_a, 1'b0, "either mode zero reload edge");
        step(16'd9, 1'b0, 1'b1, 1'b0);
        chk("R8", pwm_a, 1'b1, "released, zero high applies");

        // reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", pwm_a, 1'b0, "A after mid reset");
        chk("R1", pwm_b, 1'b0, "B after mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        step(16'd0, 1'b1, 1'b1, 1'b0);
        chk("R1", pwm_a, 1'b0, "A words cleared by reset");
        chk("R1", pwm_b, 1'b0, "B words cleared by reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule